// File: doc/BRIEF.md
# I2C Register Access Slave

This block lets an I2C master reach a bank of sixteen 8-bit registers. It oversamples the SCL and SDA lines with the system clock and recognises START and STOP. It answers only to its own 7-bit address. Six bits of that address are fixed and the lowest bit comes from a strap input. After its address, the master sends a write or a read. In a write, a pointer byte comes next, followed by any number of data bytes. In a read, the slave returns register contents beginning at the pointer left by the previous access. After each data byte, written or read, the pointer steps forward by one and wraps around the bank.

The slave pulls SDA through a single drive-low enable, and the pad logic outside the block turns that into an open-drain output. It holds no clock-stretching, arbitration or general-call logic. The system clock must run well above the bus bit rate, because every bus event is seen through the synchronizer.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 0011000 with its lowest bit replaced by `addr_sel`. For any other address it gives no acknowledge, leaves SDA released for the rest of the transaction, and stores nothing until the next START.
- R2: The address byte arrives MSB first, and its last bit selects the direction: 0 means write and 1 means read.
- R3: In an addressed write, the slave acknowledges the address byte, the pointer byte and every data byte by holding SDA low through the ninth SCL pulse.
- R4: In a write, the first byte after the address sets the pointer, using its low 4 bits to select one of 16 registers. Each byte after that is stored in the register the pointer selects.
- R5: The pointer advances by one after each data byte, written or read, and wraps from 15 to 0.
- R6: In a read, the slave sends register contents MSB first. It starts with the register the current pointer selects, immediately after acknowledging the address.
- R7: While reading, a master ACK after a byte makes the slave send the next register. A master NACK makes it release SDA and wait for STOP or START, and a later read continues at the register after the last one sent.
- R8: A repeated START at any point restarts address reception, and the pointer keeps its value.
- R9: The SDA drive enable changes only while SCL is low.
- R10: After reset, SDA is released, all registers hold 0x00 and the pointer is 0.
- R11: A STOP condition releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that supplies address bit 0 |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | When high, the pad pulls SDA low |

## Verification
A corrupted pointer or bank entry cannot stay hidden for long: the next read sends the wrong byte, within eight SCL periods of the address acknowledge. A wrong state in the byte sequencer shows up within one byte. The slave then acknowledges in the wrong ninth-bit slot, drives SDA during a master bit, or fails to let go of SDA after a NACK or STOP, and the bench sees each of these on the shared line. The sweep over every address with both strap values checks the address decoder. Reading the bank back in bursts that wrap past register 15 checks the pointer arithmetic.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned REGS_DEF  = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned SYNC_DEF  = 2;
    localparam logic [5:0]  DEV_UPPER = 6'b001100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_SACK,
        ST_MACK
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [6:0] dev_addr(input logic strap);
        return {DEV_UPPER, strap};
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_regport_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output line_ev_t ev
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_raw;
                    sda_q <= sda_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_raw};
                    sda_q <= {sda_q[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_q[STAGES-1];
        ev.sda   = sda_q[STAGES-1];
        ev.rise  = ~scl_d & scl_q[STAGES-1];
        ev.fall  = scl_d & ~scl_q[STAGES-1];
        ev.start = scl_d & scl_q[STAGES-1] & sda_d & ~sda_q[STAGES-1];
        ev.stop  = scl_d & scl_q[STAGES-1] & ~sda_d & sda_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
    import i2c_regport_pkg::*;
#(
    parameter int unsigned REGS = REGS_DEF,
    parameter int unsigned DW   = DATA_W,
    localparam int unsigned PW  = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [DW-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [REGS-1:0][DW-1:0] bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(REGS); i++) begin
                if (wr_ptr == PW'(i)) bank[i] <= wr_data;
            end
        end
    end

    assign rd_data = bank[rd_ptr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bank[$past(wr_ptr)] == $past(wr_data)); // R4

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_regport_pkg::*;
#(
    parameter int unsigned REGS   = REGS_DEF,
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_sel,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned PW    = $clog2(REGS);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    line_ev_t            ev;
    phase_e              st;
    phase_e              st_after;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   shreg;
    logic [DATA_W-1:0]   txb;
    logic [PW-1:0]       ptr;
    logic                sda_oe;
    logic                mnack;
    logic                wr_en;
    logic                addr_hit;
    logic [DATA_W-1:0]   rd_data;

    i2c_line_sampler #(.STAGES(STAGES)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (ev)
    );

    i2c_reg_file #(.REGS(REGS), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ptr  (ptr),
        .wr_data (shreg),
        .rd_ptr  (ptr),
        .rd_data (rd_data)
    );

    assign addr_hit = (shreg[7:1] == dev_addr(addr_sel));
    assign wr_en    = ev.fall && (st == ST_WR) && (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            st_after <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txb      <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            mnack    <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.rise) begin
            unique case (st)
                ST_ADDR, ST_PTR, ST_WR: begin
                    shreg <= {shreg[DATA_W-2:0], ev.sda};
                    cnt   <= cnt + 1'b1;
                end
                ST_RD:   cnt   <= cnt + 1'b1;
                ST_MACK: mnack <= ev.sda;
                default: ;
            endcase
        end else if (ev.fall) begin
            unique case (st)
                ST_ADDR: begin
                    if (cnt == FULL) begin
                        if (addr_hit) begin
                            st       <= ST_SACK;
                            sda_oe   <= 1'b1;
                            st_after <= shreg[0] ? ST_RD : ST_PTR;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_PTR: begin
                    if (cnt == FULL) begin
                        ptr      <= shreg[PW-1:0];
                        st       <= ST_SACK;
                        sda_oe   <= 1'b1;
                        st_after <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (cnt == FULL) begin
                        ptr      <= ptr + 1'b1;
                        st       <= ST_SACK;
                        sda_oe   <= 1'b1;
                        st_after <= ST_WR;
                    end
                end
                ST_SACK: begin
                    cnt <= '0;
                    if (st_after == ST_RD) begin
                        txb    <= rd_data;
                        ptr    <= ptr + 1'b1;
                        sda_oe <= ~rd_data[DATA_W-1];
                        st     <= ST_RD;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= st_after;
                    end
                end
                ST_RD: begin
                    if (cnt == FULL) begin
                        sda_oe <= 1'b0;
                        st     <= ST_MACK;
                    end else begin
                        txb    <= {txb[DATA_W-2:0], 1'b0};
                        sda_oe <= ~txb[DATA_W-2];
                    end
                end
                ST_MACK: begin
                    if (mnack) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt    <= '0;
                        txb    <= rd_data;
                        ptr    <= ptr + 1'b1;
                        sda_oe <= ~rd_data[DATA_W-1];
                        st     <= ST_RD;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_low = sda_oe;

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !ev.scl); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe); // R11

    AST_NO_ACK_FOREIGN: assert property (@(posedge clk) disable iff (rst)
        (ev.fall && st == ST_ADDR && cnt == FULL && !addr_hit) |=> !sda_oe); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr == $past(ptr) + PW'(1)); // R5

    AST_NACK_LETS_GO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MACK && ev.fall && mnack && !ev.start && !ev.stop) |=> (!sda_oe && st == ST_IDLE)); // R7

endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drv;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    logic [7:0] model [16];
    logic [3:0] mptr = 4'd0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_drv;

    i2c_reg_slave uut (
        .clk          (clk),
        .rst          (rst),
        .addr_sel     (strap),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_pull_low (sda_drv)
    );

    logic prev_drv = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && (sda_drv !== prev_drv)) r9_viol++;
        prev_drv <= sda_drv;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic m_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~m_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    function automatic logic [6:0] own_addr();
        return {6'b001100, strap};
    endfunction

    task automatic set_ptr(input logic [3:0] p);
        logic a;
        bus_start();
        put_byte({own_addr(), 1'b0}, a); check8("R3 addr ack", {7'd0, a}, 8'd1);
        put_byte({4'd0, p}, a);          check8("R3 ptr ack", {7'd0, a}, 8'd1);
        bus_stop();
        check8("R11 released after stop", {7'd0, sda_drv}, 8'd0);
        mptr = p;
    endtask

    task automatic read_burst(input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte({own_addr(), 1'b1}, a); check8("R2 read addr ack", {7'd0, a}, 8'd1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            check8(req, b, model[mptr]);
            mptr = mptr + 4'd1;
        end
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);
        check8("R10 SDA released after reset", {7'd0, sda_drv}, 8'd0);

        // R1 sweep: every address, both strap values
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            tick(2);
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                put_byte({ad[6:0], 1'b0}, a);
                check8("R1 address decode", {7'd0, a}, {7'd0, (ad[6:0] == own_addr())});
                bus_stop();
            end
        end

        strap = 1'b1;
        tick(2);
        // R10: bank reads zero after reset
        set_ptr(4'd0);
        read_burst(16, "R10 reset contents");

        // R4 R5: burst write from 5 wrapping through all 16 registers
        bus_start();
        put_byte({own_addr(), 1'b0}, a); check8("R3 addr ack", {7'd0, a}, 8'd1);
        put_byte(8'd5, a);               check8("R4 ptr ack", {7'd0, a}, 8'd1);
        mptr = 4'd5;
        for (int i = 0; i < 16; i++) begin
            b = 8'(i * 37 + 11);
            put_byte(b, a);
            check8("R3 data ack", {7'd0, a}, 8'd1);
            model[mptr] = b;
            mptr = mptr + 4'd1;
        end
        bus_stop();
        set_ptr(4'd0);
        read_burst(16, "R5 burst write wrap readback");

        // R8 R6: pointer set then repeated START into read, wraps 15->0
        bus_start();
        put_byte({own_addr(), 1'b0}, a);
        put_byte(8'd14, a);
        mptr = 4'd14;
        bus_start();
        put_byte({own_addr(), 1'b1}, a); check8("R8 repeated start addr ack", {7'd0, a}, 8'd1);
        for (int i = 0; i < 4; i++) begin
            get_byte(i != 3, b);
            check8("R6 read wrap", b, model[mptr]);
            mptr = mptr + 4'd1;
        end
        bus_stop();
        // R7: after NACK a new read resumes at the next register
        read_burst(1, "R7 resume after nack");

        // R1: foreign write stores nothing
        bus_start();
        put_byte({7'h18, 1'b0}, a); check8("R1 foreign addr nack", {7'd0, a}, 8'd0);
        put_byte(8'd3, a);          check8("R1 foreign ptr nack", {7'd0, a}, 8'd0);
        put_byte(8'hAA, a);         check8("R1 foreign data nack", {7'd0, a}, 8'd0);
        bus_stop();
        set_ptr(4'd3);
        read_burst(1, "R1 register untouched");

        // R1 R2: foreign read leaves line released
        bus_start();
        put_byte({7'h18, 1'b1}, a); check8("R2 foreign read nack", {7'd0, a}, 8'd0);
        get_byte(1'b0, b);          check8("R1 foreign read idle line", b, 8'hFF);
        bus_stop();

        // strap low: device answers at 0x18
        strap = 1'b0;
        tick(2);
        bus_start();
        put_byte({7'h18, 1'b0}, a); check8("R1 strap low ack", {7'd0, a}, 8'd1);
        put_byte(8'd7, a);
        put_byte(8'h5C, a);         check8("R4 data ack", {7'd0, a}, 8'd1);
        model[7] = 8'h5C;
        bus_stop();
        set_ptr(4'd7);
        read_burst(1, "R4 strap low write");

        // R8: repeated START in the middle of a write
        bus_start();
        put_byte({own_addr(), 1'b0}, a);
        put_byte(8'd9, a);
        put_byte(8'h33, a);
        model[9] = 8'h33;
        bus_start();
        put_byte({own_addr(), 1'b0}, a); check8("R8 restart ack", {7'd0, a}, 8'd1);
        put_byte(8'hFC, a);              // R4: only the low 4 bits select register 12
        put_byte(8'h44, a);
        model[12] = 8'h44;
        bus_stop();
        set_ptr(4'd8);
        read_burst(6, "R8 restart write readback");

        check8("R9 SDA moved while SCL high", 8'(r9_viol), 8'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule